// File: doc/BRIEF.md
# Dual-Mode Burst Address Sequencer

This block produces the memory address for every beat of a four-beat burst in a synchronous burst memory. A start address is captured when either of two active-low address strobes is asserted at a rising clock edge. One strobe is used by the processor side and the other by the controller side. After the capture, each rising edge at which the active-low step input is low moves the burst to its next beat. An edge with the step input high holds the current beat, which suspends the burst. Read bursts and write bursts use the same sequencer, so the block has no read/write input.

A static order-select input chooses one of two beat orders. The first is an interleaved order, in which each beat address is the start address XORed with the beat count. The second is a linear order, in which the beat count is added to the start address and the sum wraps within the four-beat window. Only the two low address bits are sequenced. The bits above them pass through unchanged from the captured address. The output address and the beat index are both registered, and both show the state reached at the most recent clock edge.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high `rst` clears the captured base address and the beat counter. One cycle later `addr_out` and `beat_idx` both read zero.
- R2: At a rising edge where `strb_cpu_n` or `strb_ctl_n` is low, `addr_in` is captured as the base. From the next cycle `addr_out` equals the captured address and `beat_idx` is 0.
- R3: At a rising edge with both strobes high and `step_n` low, `beat_idx` increases by one, modulo 4.
- R4: At a rising edge with both strobes high and `step_n` high, `beat_idx` and `addr_out` keep their values. This suspends the burst.
- R5: With `order_sel` = 1 (interleaved), `addr_out[1:0]` equals the captured start bits XOR `beat_idx`. For example, start 01 gives 01, 00, 11, 10.
- R6: With `order_sel` = 0 (linear), `addr_out[1:0]` equals the captured start bits plus `beat_idx`, modulo 4. For example, start 11 gives 11, 00, 01, 10.
- R7: A strobe and a low `step_n` at the same edge perform a load. `beat_idx` becomes 0 and no step is taken.
- R8: `addr_out[ADDR_W-1:2]` always equals the upper bits of the most recently captured address.
- R9: After four steps the burst wraps. `beat_idx` returns to 0 and `addr_out` returns to the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Advance to the next beat, active low |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_in | input | ADDR_W | Start address to capture |
| addr_out | output | ADDR_W | Registered address of the current beat |
| beat_idx | output | 2 | Registered beat count since the last load |

## Verification
A load and a step can arrive at the same clock edge. In that case the load must win, and the beat count must restart at zero rather than at one. The bench forces this collision on purpose, once through each strobe. Its reference model then expects a fresh start address at beat zero. Random traffic also produces collisions. In every cycle, including collision cycles, the model's address and beat are compared with the outputs.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] cnt_q,
  output logic [BEAT_W-1:0] cnt_d
);

  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = '0;
    else if (step) cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_d
);

  logic [ADDR_W-1:0] base_q;

  assign base_d = load ? addr_in : base_q;

  always_ff @(posedge clk) begin
    if (rst) base_q <= '0;
    else     base_q <= base_d;
  end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  input  order_e            order,
  output logic [BEAT_W-1:0] lo
);

  logic [BEAT_W-1:0] xor_lo;
  logic [BEAT_W-1:0] lin_lo;

  for (genvar i = 0; i < BEAT_W; i++) begin : g_xor
    assign xor_lo[i] = start[i] ^ beat[i];
  end

  assign lin_lo = start + beat;
  assign lo     = (order == ORD_XOR) ? xor_lo : lin_lo;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strb_cpu_n,
  input  logic              strb_ctl_n,
  input  logic              step_n,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [BEAT_W-1:0] beat_idx
);

  logic              load;
  logic              step;
  logic [BEAT_W-1:0] cnt_q;
  logic [BEAT_W-1:0] cnt_d;
  logic [ADDR_W-1:0] base_d;
  logic [BEAT_W-1:0] lo_d;
  order_e            order;

  assign load  = ~strb_cpu_n | ~strb_ctl_n;
  assign step  = ~step_n;
  assign order = order_e'(order_sel);

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .step  (step),
    .cnt_q (cnt_q),
    .cnt_d (cnt_d)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .addr_in (addr_in),
    .base_d  (base_d)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start (base_d[BEAT_W-1:0]),
    .beat  (cnt_d),
    .order (order),
    .lo    (lo_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out <= '0;
      beat_idx <= '0;
    end else begin
      addr_out <= {base_d[ADDR_W-1:BEAT_W], lo_d};
      beat_idx <= cnt_d;
    end
  end

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              strb_cpu_n,
  input logic              strb_ctl_n,
  input logic              step_n,
  input logic              order_sel,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic [BEAT_W-1:0] beat_idx
);

  logic              ld;
  logic [BEAT_W-1:0] xor_key;
  logic [BEAT_W-1:0] lin_key;

  assign ld      = ~strb_cpu_n | ~strb_ctl_n;
  assign xor_key = addr_out[BEAT_W-1:0] ^ beat_idx;
  assign lin_key = addr_out[BEAT_W-1:0] - beat_idx;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (addr_out == '0) && (beat_idx == '0));

  p_load_seed_r2: assert property (@(posedge clk) disable iff (rst)
    ld |=> (beat_idx == '0) && (addr_out == $past(addr_in)));

  p_step_inc_r3: assert property (@(posedge clk) disable iff (rst)
    (!ld && !step_n) |=> beat_idx == BEAT_W'($past(beat_idx) + 1'b1));

  p_suspend_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!ld && step_n) |=> $stable(beat_idx));

  p_xor_key_r5: assert property (@(posedge clk) disable iff (rst)
    (!ld && order_sel && $past(order_sel)) |=> $stable(xor_key));

  p_lin_key_r6: assert property (@(posedge clk) disable iff (rst)
    (!ld && !order_sel && !$past(order_sel)) |=> $stable(lin_key));

  p_load_over_step_r7: assert property (@(posedge clk) disable iff (rst)
    (ld && !step_n) |=> beat_idx == '0);

  p_upper_pass_r8: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .strb_cpu_n (strb_cpu_n),
  .strb_ctl_n (strb_ctl_n),
  .step_n     (step_n),
  .order_sel  (order_sel),
  .addr_in    (addr_in),
  .addr_out   (addr_out),
  .beat_idx   (beat_idx)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          strb_cpu_n = 1'b1;
  logic          strb_ctl_n = 1'b1;
  logic          step_n = 1'b1;
  logic          order_sel = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [BW-1:0] beat_idx;

  int checks = 0;
  int errors = 0;
  int m_base = 0;
  int m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) u_burst_addr_seq (
    .clk        (clk),
    .rst        (rst),
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .step_n     (step_n),
    .order_sel  (order_sel),
    .addr_in    (addr_in),
    .addr_out   (addr_out),
    .beat_idx   (beat_idx)
  );

  function automatic int exp_addr(input int base, input int cnt, input logic m);
    int lo;
    lo = m ? ((base & 3) ^ cnt) : (((base & 3) + cnt) % 4);
    return (base & ~3) | lo;
  endfunction

  task automatic compare(input string tag, input logic m);
    int ea;
    ea = exp_addr(m_base, m_cnt, m);
    checks++;
    if (int'(addr_out) != ea) begin
      errors++;
      $display("FAIL %s addr_out actual=%h expected=%h", tag, addr_out, ea[AW-1:0]);
    end
    checks++;
    if (int'(beat_idx) != m_cnt) begin
      errors++;
      $display("FAIL %s beat_idx actual=%0d expected=%0d", tag, beat_idx, m_cnt);
    end
  endtask

  task automatic cyc(input logic a_n, input logic b_n, input logic s_n,
                     input logic m, input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    strb_cpu_n = a_n; strb_ctl_n = b_n; step_n = s_n; order_sel = m; addr_in = a;
    if (!a_n || !b_n) begin
      m_base = int'(a); m_cnt = 0;
    end else if (!s_n) begin
      m_cnt = (m_cnt + 1) % 4;
    end
    @(posedge clk);
    #1;
    compare(tag, m);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    compare("R1", 1'b1);
    @(negedge clk);
    rst = 1'b0;

    // R2 / R5 / R9: processor strobe, interleaved, start 01, full wrap
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 16'hA5A1, "R2");
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b0, 1'b1, 16'h0, "R5");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 16'h0, "R9");

    // R2 / R6: controller strobe, linear, start 11
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 16'h3C03, "R2");
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 16'h0, "R6");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 16'h0, "R9");

    // R3 / R4: step then suspend for several cycles
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 16'h1232, "R2");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 16'hFFFF, "R3");
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b1, 1'b0, 16'hFFFF, "R4");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 16'hFFFF, "R3");

    // R7: load and step at the same edge, through each strobe
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 16'h8002, "R7");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 16'h0, "R3");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 16'h4441, "R7");

    // R8: upper bits unaffected by addr_in changes while stepping
    for (int i = 0; i < 5; i++)
      cyc(1'b1, 1'b1, 1'b0, 1'b1, AW'(16'h1111 * i), "R8");

    // Mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic ld_a, ld_b, s, m;
      ld_a = ($urandom_range(0, 5) != 0);
      ld_b = ($urandom_range(0, 5) != 0);
      s    = ($urandom_range(0, 3) == 0);
      m    = (i / 50) % 2 == 0;
      cyc(ld_a, ld_b, s, m, AW'($urandom), "R3");
    end

    // R1: reset in the middle of a burst
    @(negedge clk);
    rst = 1'b1;
    m_base = 0; m_cnt = 0;
    @(posedge clk);
    #1;
    compare("R1", order_sel);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule